// File: doc/BRIEF.md
# Write completion status generator

This block times the busy period of a self-timed program or erase operation and shapes the byte that reads return while that operation runs. The command sequencer sends it a one-cycle start pulse for a program or for an erase, together with the data byte last loaded for that operation. From then on, an internal down-counter measures the operation's length in clock cycles. The block raises a busy flag for that time and gives a one-cycle done pulse when the timer expires. An erase can be cut short with an abort input. In that case the sector may be left only partly erased.

While busy, the block replaces the top two bits of the read path with status. Bit 7 carries the inverse of bit 7 of the loaded byte. Bit 6 changes value after every read strobe. Bits 5..0 still follow the array. Software can therefore find the end of the operation in three ways: by polling bit 7, by watching bit 6 stop changing, or by two successive reads that match. When the block is not busy, the array byte passes through unchanged.

Top module: `wr_status_gen`

## Requirements
- R1: While reset is held low, busy and done are 0 and rd_data equals array_data.
- R2: A prog_start seen in an idle cycle raises busy from the next cycle, and busy then stays high for exactly PROG_CYC cycles.
- R3: An erase_start seen in an idle cycle raises busy from the next cycle, and busy then stays high for exactly ERASE_CYC cycles.
- R4: When the timer ends an operation, done is 1 for exactly one cycle: the first cycle in which busy is 0 again.
- R5: While busy, rd_data bit 7 is the inverse of bit 7 of the load_data value captured with the start pulse.
- R6: While busy, rd_data bit 6 is 0 on the first read after a start and flips after each cycle with rd_strobe high. Bits 5..0 equal array_data.
- R7: While not busy, rd_data equals array_data on all bits, and rd_strobe has no effect, so repeated reads return identical data.
- R8: An abort seen while an erase is busy drops busy in the next cycle and gives no done pulse.
- R9: An abort during a program has no effect, and the program still lasts PROG_CYC cycles.
- R10: Start pulses while busy are ignored: neither the captured bit 7 nor the remaining duration changes.
- R11: If prog_start and erase_start arrive in the same idle cycle, the operation is a program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_start | input | 1 | One-cycle program start from the sequencer |
| erase_start | input | 1 | One-cycle erase start from the sequencer |
| load_data | input | DW | Last loaded data byte, captured with a start |
| abort | input | 1 | Stops a running erase |
| rd_strobe | input | 1 | A read of the status path happens this cycle |
| array_data | input | DW | Byte from the array read path |
| rd_data | output | DW | Byte returned to the reader |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the timer ends an operation |

## Verification
rd_data depends combinationally on array_data and on state, so the bench compares it in the same cycle, shortly after driving the inputs at the falling edge. The value of bit 6 it expects is the one present before that cycle's strobe takes effect. Busy and done are registered. The bench checks them at the falling edge after the rising edge that sampled a start or an abort, so busy is due one cycle after a start and one cycle after an erase abort. Done is due in the first cycle after the last busy cycle. A reference model in the bench advances once at each rising edge, and the directed runs count busy cycles to compare against PROG_CYC and ERASE_CYC.

// File: rtl/wr_status_gen.sv
module wr_status_gen #(
  parameter int DW        = 8,
  parameter int PROG_CYC  = 1200,
  parameter int ERASE_CYC = 120000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_start,
  input  logic          erase_start,
  input  logic [DW-1:0] load_data,
  input  logic          abort,
  input  logic          rd_strobe,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done
);
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic          busy_q, done_q, erase_q, pol_q, tog_q;
  logic [CW-1:0] cnt_q;
  logic          go, kill, last;

  assign go   = !busy_q && (prog_start || erase_start);
  assign kill = busy_q && erase_q && abort;
  assign last = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      erase_q <= 1'b0;
      pol_q   <= 1'b0;
      tog_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        busy_q  <= 1'b1;
        erase_q <= !prog_start;
        pol_q   <= ~load_data[DW-1];
        tog_q   <= 1'b0;
        cnt_q   <= prog_start ? CW'(PROG_CYC - 1) : CW'(ERASE_CYC - 1);
      end else if (kill) begin
        busy_q <= 1'b0;
      end else if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
        if (rd_strobe) tog_q <= ~tog_q;
      end
    end
  end

  assign rd_data = busy_q ? {pol_q, tog_q, array_data[DW-3:0]} : array_data;
  assign busy    = busy_q;
  assign done    = done_q;

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (prog_start || erase_start)) |=> busy);
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R8
  abort_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && erase_q && abort) |=> (!busy && !done));
  // R9
  abort_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !erase_q && abort && cnt_q != '0) |=> busy);
  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_strobe && cnt_q != '0 && !(erase_q && abort))
      |=> (rd_data[DW-2] != $past(rd_data[DW-2])));
  // R10
  hold_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != '0 && !(erase_q && abort)) |=> $stable(rd_data[DW-1]));
endmodule

// File: tb/wr_status_gen_bench.sv
module wr_status_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PC = 12;
  localparam int EC = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ps = 0, es = 0, ab = 0, rd = 0;
  logic [7:0] ld = 0, arr = 0;
  logic [7:0] rd_data;
  logic busy, done;

  int total = 0, bad = 0, cyc = 0;
  bit fin = 0;

  // reference state
  bit r_busy = 0, r_done = 0, r_erase = 0, r_b7 = 0, r_tog = 0;
  int r_left = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wr_status_gen #(.DW(8), .PROG_CYC(PC), .ERASE_CYC(EC)) u_wr_status_gen (
    .clk(clk), .rst_n(rst_n), .prog_start(ps), .erase_start(es),
    .load_data(ld), .abort(ab), .rd_strobe(rd), .array_data(arr),
    .rd_data(rd_data), .busy(busy), .done(done));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    return r_busy ? {r_b7, r_tog, a[5:0]} : a;
  endfunction

  task automatic step(bit p, bit e, bit a, bit r, logic [7:0] l, logic [7:0] d);
    ps = p; es = e; ab = a; rd = r; ld = l; arr = d;
    #1;
    chk(r_erase ? "R3" : "R2", busy, r_busy);
    chk("R4", done, r_done);
    if (r_busy) begin
      chk("R5", rd_data[7], r_b7);
      chk("R6", rd_data[6:0], {r_tog, d[5:0]});
    end else chk("R7", rd_data, d);
    @(posedge clk);
    r_done = 0;
    if (!r_busy) begin
      if (p || e) begin
        r_busy = 1; r_erase = !p; r_b7 = ~l[7]; r_tog = 0; r_left = p ? PC : EC;
      end
    end else if (a && r_erase) r_busy = 0;
    else begin
      if (r) r_tog = ~r_tog;
      r_left--;
      if (r_left == 0) begin r_busy = 0; r_done = 1; end
    end
    @(negedge clk);
  endtask

  // run until idle with strobes, optional abort at cycle k, return busy length
  task automatic run(int k, output int n);
    n = 0;
    while (busy && n < 1000) begin
      step(0, 0, n == k, 1, 8'h00, 8'($urandom));
      n++;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !fin) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] v;
    void'($urandom(32'd7));
    arr = 8'hA5;
    #(3*CLK_PERIOD/2 + 1);
    // R1
    chk("R1", busy, 0); chk("R1", done, 0); chk("R1", rd_data, 8'hA5);
    @(negedge clk); rst_n = 1;

    // R7 idle passthrough with strobes
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 8'hFF, 8'h3C);
    chk("R7", rd_data, 8'h3C);

    // R2 program length, R6 first read bit6 = 0
    step(1, 0, 0, 0, 8'h80, 8'hFF);
    chk("R6", rd_data[6], 0);
    chk("R5", rd_data[7], 0);
    run(-1, n); chk("R2", n, PC);
    chk("R4", done, 1);
    step(0, 0, 0, 1, 8'h00, 8'h11);
    chk("R4", done, 0);

    // R3 erase full length
    step(0, 1, 0, 0, 8'h00, 8'h00);
    run(-1, n); chk("R3", n, EC);

    // R8 erase abort
    step(0, 1, 0, 0, 8'h7F, 8'h00);
    run(5, n); chk("R8", n, 6);
    chk("R8", busy, 0); chk("R8", done, 0);

    // R9 program abort ignored
    step(1, 0, 0, 0, 8'h00, 8'h00);
    run(3, n); chk("R9", n, PC);

    // R10 start while busy
    step(1, 0, 0, 0, 8'h00, 8'h00);
    step(0, 1, 0, 0, 8'hFF, 8'h00);
    chk("R10", rd_data[7], 1);
    step(1, 0, 0, 0, 8'hFF, 8'h00);
    chk("R10", rd_data[7], 1);
    run(-1, n); chk("R10", n, PC - 2);

    // R11 simultaneous starts
    step(1, 1, 0, 0, 8'h00, 8'h00);
    run(-1, n); chk("R11", n, PC);

    // R7 stable identical reads after completion
    v = 8'($urandom);
    step(0, 0, 0, 1, 8'h00, v);
    chk("R7", rd_data, v);
    step(0, 0, 0, 1, 8'h00, v);
    chk("R7", rd_data, v);

    // random mix
    for (int i = 0; i < 3000; i++)
      step(($urandom % 20) == 0, ($urandom % 25) == 0, ($urandom % 30) == 0,
           $urandom % 2, 8'($urandom), 8'($urandom));

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule